// File: doc/BRIEF.md
# Keyed RTC Control and Status Register

This block holds the control state for a low-frequency oscillator and real-time-clock domain. It sits on a plain synchronous bus with an address, write data, a write enable and combinational read data. The clock source select bit is guarded: it changes only when the upper half of the same write word carries the protection key. The block also holds an auto-switch enable and an auto-switch pending flag, and a two-bit watchdog mode register.

Writes to the time and alarm registers are not stored here. The block captures the written word and holds it steady. It then passes a request across to the slow 32 kHz domain through a four-phase request/acknowledge handshake, with a synchronizer in each direction. The slow domain gets a single-cycle load strobe. A busy flag for each channel is visible in the control register until the acknowledge has returned and fallen again. A second write that arrives while its channel is busy is dropped, and a sticky error bit records it.

Top module: `rtc_keyed_ctrl`

## Requirements
- R1: After reset the control register (address 0x100) reads 0x00004000, the watchdog register (0x094) reads 0 and the error register (0x104) reads 0.
- R2: Control bit 0 (source select) takes the written value only when write bits 31:16 equal 0x16AA. With any other key it is unchanged, while the other writable control bits in that write still take effect.
- R3: Control bits 31:16, 13:10 and 7:1 always read 0. Watchdog and error registers read 0 above bit 1.
- R4: Control bit 14 (auto-switch enable) is read/write. Control bit 15 (auto-switch pending) is read/write and is also set by a pulse on `osc_autosw_evt`. When the pulse and a write fall in the same cycle, the pulse wins.
- R5: A write to the time register (0x114) while control bit 8 is clear sets bit 8 from the next cycle and captures the word on `time_data`. A write to the alarm register (0x120) does the same with bit 9 and `alarm_data`.
- R6: Each accepted time or alarm write produces exactly one `slow_time_load` or `slow_alarm_load` pulse in the slow domain, with the captured word on the data output. Its busy bit clears within 10 slow-clock cycles of the write.
- R7: Software writes to control bits 8 and 9 have no effect on them.
- R8: A time or alarm write that arrives while its busy bit is set is dropped: the data output is unchanged and no extra load occurs. It also sets error bit 0 (time) or bit 1 (alarm), which stays set.
- R9: Writing 1 to an error register bit clears it. Writing 0 leaves it unchanged.
- R10: Watchdog bit 0 (enable) and bit 1 (reset enable) are read/write and drive `wdog_en` and `wdog_rst_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| slow_clk | input | 1 | 32 kHz domain clock |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write enable, one write per cycle |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| osc_autosw_evt | input | 1 | Pulse from oscillator monitor: automatic switch happened |
| osc_src_sel | output | 1 | Clock source select |
| autosw_en | output | 1 | Automatic source switch enable |
| wdog_en | output | 1 | Watchdog enable |
| wdog_rst_en | output | 1 | Watchdog may drive system reset |
| time_data | output | 32 | Captured time word, stable while busy |
| alarm_data | output | 32 | Captured alarm word, stable while busy |
| slow_time_load | output | 1 | Slow-domain strobe to load time_data |
| slow_alarm_load | output | 1 | Slow-domain strobe to load alarm_data |

## Verification
Two pairs of events can land in the same bus cycle. The first pair is a pulse on the auto-switch event and a software write of 0 to the pending bit. The bench drives both in one cycle and expects the pending bit to read 1. The second pair is a second time or alarm write and the ongoing slow-domain handshake of the first. The bench issues two writes back to back. It expects the first word to stay on the data output, one load strobe in total, and the error bit set.

// File: rtl/rtcc_pkg.sv
package rtcc_pkg;
   localparam int unsigned NUM_CHAN  = 2;
   localparam int unsigned CH_TIME   = 0;
   localparam int unsigned CH_ALARM  = 1;
   localparam int unsigned BIT_SRC   = 0;
   localparam int unsigned BIT_BUSY0 = 8;
   localparam int unsigned BIT_AEN   = 14;
   localparam int unsigned BIT_APEND = 15;

   typedef enum logic [2:0] {
      REG_NONE,
      REG_CTRL,
      REG_WDOG,
      REG_ERR,
      REG_TIME,
      REG_ALARM
   } reg_sel_e;
endpackage

// File: rtl/rtcc_sync.sv
module rtcc_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rtcc_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/rtcc_busy_chan.sv
module rtcc_busy_chan #(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slow_clk,
   input  logic              wr_req,
   input  logic [DATA_W-1:0] wr_data,
   output logic              busy,
   output logic              drop,
   output logic [DATA_W-1:0] hold_data,
   output logic              slow_load
);
   logic req_q;
   logic ack_b;
   logic req_s;
   logic req_s_d;
   logic accept;

   assign accept = wr_req & ~busy;
   assign drop   = wr_req & busy;
   assign busy   = req_q | ack_b;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q     <= 1'b0;
         hold_data <= '0;
      end else if (accept) begin
         req_q     <= 1'b1;
         hold_data <= wr_data;
      end else if (req_q && ack_b) begin
         req_q     <= 1'b0;
      end
   end

   rtcc_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk   (slow_clk),
      .rst_n (rst_n),
      .d     (req_q),
      .q     (req_s)
   );

   always_ff @(posedge slow_clk or negedge rst_n) begin
      if (!rst_n) req_s_d <= 1'b0;
      else        req_s_d <= req_s;
   end

   assign slow_load = req_s & ~req_s_d;

   rtcc_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (req_s),
      .q     (ack_b)
   );

   // R6
   req_drop_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_q) |-> $past(ack_b));

   // R8
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(hold_data));

   // R6
   single_load_chk: assert property (@(posedge slow_clk) disable iff (!rst_n)
      slow_load |=> !slow_load);
endmodule

// File: rtl/rtc_keyed_ctrl.sv
module rtc_keyed_ctrl
   import rtcc_pkg::*;
#(
   parameter int unsigned        ADDR_W      = 12,
   parameter int unsigned        DATA_W      = 32,
   parameter int unsigned        KEY_W       = 16,
   parameter logic [KEY_W-1:0]   KEY_VAL     = 16'h16AA,
   parameter int unsigned        SYNC_STAGES = 2,
   parameter logic               AEN_RST     = 1'b1,
   parameter logic [ADDR_W-1:0]  CTRL_ADDR   = 12'h100,
   parameter logic [ADDR_W-1:0]  WDOG_ADDR   = 12'h094,
   parameter logic [ADDR_W-1:0]  ERR_ADDR    = 12'h104,
   parameter logic [ADDR_W-1:0]  TIME_ADDR   = 12'h114,
   parameter logic [ADDR_W-1:0]  ALARM_ADDR  = 12'h120
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slow_clk,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              osc_autosw_evt,
   output logic              osc_src_sel,
   output logic              autosw_en,
   output logic              wdog_en,
   output logic              wdog_rst_en,
   output logic [DATA_W-1:0] time_data,
   output logic [DATA_W-1:0] alarm_data,
   output logic              slow_time_load,
   output logic              slow_alarm_load
);
   localparam int unsigned KEY_LSB = DATA_W - KEY_W;

   if (DATA_W < 32) begin : g_bad_width
      $error("rtc_keyed_ctrl: DATA_W must be at least 32");
   end
   if (KEY_W != DATA_W / 2) begin : g_bad_key
      $error("rtc_keyed_ctrl: key must fill the upper half-word");
   end

   reg_sel_e                          sel;
   logic                              key_ok;
   logic                              ctrl_we;
   logic                              wdog_we;
   logic                              err_we;
   logic                              src_q;
   logic                              aen_q;
   logic                              pend_q;
   logic [1:0]                        wdog_q;
   logic [NUM_CHAN-1:0]               err_q;
   logic [NUM_CHAN-1:0]               chan_req;
   logic [NUM_CHAN-1:0]               chan_busy;
   logic [NUM_CHAN-1:0]               chan_drop;
   logic [NUM_CHAN-1:0]               chan_load;
   logic [NUM_CHAN-1:0][DATA_W-1:0]   chan_data;

   always_comb begin
      if      (bus_addr == CTRL_ADDR)  sel = REG_CTRL;
      else if (bus_addr == WDOG_ADDR)  sel = REG_WDOG;
      else if (bus_addr == ERR_ADDR)   sel = REG_ERR;
      else if (bus_addr == TIME_ADDR)  sel = REG_TIME;
      else if (bus_addr == ALARM_ADDR) sel = REG_ALARM;
      else                             sel = REG_NONE;
   end

   assign key_ok  = (bus_wdata[KEY_LSB +: KEY_W] == KEY_VAL);
   assign ctrl_we = bus_we && (sel == REG_CTRL);
   assign wdog_we = bus_we && (sel == REG_WDOG);
   assign err_we  = bus_we && (sel == REG_ERR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q  <= 1'b0;
         aen_q  <= AEN_RST;
         pend_q <= 1'b0;
      end else begin
         if (ctrl_we && key_ok) src_q <= bus_wdata[BIT_SRC];
         if (ctrl_we)           aen_q <= bus_wdata[BIT_AEN];
         if (osc_autosw_evt)    pend_q <= 1'b1;
         else if (ctrl_we)      pend_q <= bus_wdata[BIT_APEND];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       wdog_q <= 2'b00;
      else if (wdog_we) wdog_q <= bus_wdata[1:0];
   end

   for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
      localparam reg_sel_e CH_SEL = (c == CH_TIME) ? REG_TIME : REG_ALARM;

      assign chan_req[c] = bus_we && (sel == CH_SEL);

      rtcc_busy_chan #(
         .DATA_W      (DATA_W),
         .SYNC_STAGES (SYNC_STAGES)
      ) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .slow_clk  (slow_clk),
         .wr_req    (chan_req[c]),
         .wr_data   (bus_wdata),
         .busy      (chan_busy[c]),
         .drop      (chan_drop[c]),
         .hold_data (chan_data[c]),
         .slow_load (chan_load[c])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   err_q[c] <= 1'b0;
         else if (chan_drop[c])        err_q[c] <= 1'b1;
         else if (err_we && bus_wdata[c]) err_q[c] <= 1'b0;
      end

      // R8
      drop_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
         chan_drop[c] |=> err_q[c]);
   end

   always_comb begin
      bus_rdata = '0;
      case (sel)
         REG_CTRL: begin
            bus_rdata[BIT_SRC]   = src_q;
            bus_rdata[BIT_AEN]   = aen_q;
            bus_rdata[BIT_APEND] = pend_q;
            for (int c = 0; c < NUM_CHAN; c++) bus_rdata[BIT_BUSY0 + c] = chan_busy[c];
         end
         REG_WDOG: bus_rdata[1:0] = wdog_q;
         REG_ERR:  bus_rdata[NUM_CHAN-1:0] = err_q;
         default:  bus_rdata = '0;
      endcase
   end

   assign osc_src_sel     = src_q;
   assign autosw_en       = aen_q;
   assign wdog_en         = wdog_q[0];
   assign wdog_rst_en     = wdog_q[1];
   assign time_data       = chan_data[CH_TIME];
   assign alarm_data      = chan_data[CH_ALARM];
   assign slow_time_load  = chan_load[CH_TIME];
   assign slow_alarm_load = chan_load[CH_ALARM];

   // R2
   key_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == CTRL_ADDR && bus_wdata[KEY_LSB +: KEY_W] != KEY_VAL)
      |=> $stable(osc_src_sel));

   // R4
   pend_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
      osc_autosw_evt |=> (bus_addr != CTRL_ADDR) || bus_rdata[BIT_APEND]);

   // R3
   ctrl_zero_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == CTRL_ADDR) |-> (bus_rdata[KEY_LSB +: KEY_W] == '0
                                   && bus_rdata[13:10] == 4'h0 && bus_rdata[7:1] == 7'h00));

   // R10
   wdog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && bus_addr == WDOG_ADDR) |=> $stable({wdog_rst_en, wdog_en}));
endmodule

// File: tb/sim_rtc_keyed_ctrl.sv
`timescale 1ns/1ps
module sim_rtc_keyed_ctrl;
   localparam logic [11:0] A_CTRL  = 12'h100;
   localparam logic [11:0] A_WDOG  = 12'h094;
   localparam logic [11:0] A_ERR   = 12'h104;
   localparam logic [11:0] A_TIME  = 12'h114;
   localparam logic [11:0] A_ALARM = 12'h120;
   localparam int          BUSY_LIMIT = 10 * 32;

   logic        clk = 1'b0;
   logic        slow_clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_rdata;
   logic        osc_autosw_evt = 1'b0;
   logic        osc_src_sel, autosw_en, wdog_en, wdog_rst_en;
   logic [31:0] time_data, alarm_data;
   logic        slow_time_load, slow_alarm_load;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   typedef struct {
      logic [31:0] exp;
      logic [31:0] mask;
      string       tag;
   } item_t;
   item_t sb_q[$];
   bit    rd_pend = 1'b0;

   int          tload_n = 0, aload_n = 0;
   logic [31:0] tload_dat = '0, aload_dat = '0;

   always #2.5 clk = ~clk;
   always #80  slow_clk = ~slow_clk;

   rtc_keyed_ctrl u0 (
      .clk             (clk),
      .rst_n           (rst_n),
      .slow_clk        (slow_clk),
      .bus_addr        (bus_addr),
      .bus_wdata       (bus_wdata),
      .bus_we          (bus_we),
      .bus_rdata       (bus_rdata),
      .osc_autosw_evt  (osc_autosw_evt),
      .osc_src_sel     (osc_src_sel),
      .autosw_en       (autosw_en),
      .wdog_en         (wdog_en),
      .wdog_rst_en     (wdog_rst_en),
      .time_data       (time_data),
      .alarm_data      (alarm_data),
      .slow_time_load  (slow_time_load),
      .slow_alarm_load (slow_alarm_load)
   );

   always @(negedge slow_clk) begin
      if (slow_time_load)  begin tload_n++; tload_dat = time_data;  end
      if (slow_alarm_load) begin aload_n++; aload_dat = alarm_data; end
   end

   // scoreboard monitor
   always @(negedge clk) begin
      if (rd_pend && sb_q.size() > 0) begin
         item_t it;
         it = sb_q.pop_front();
         n_tests++;
         if ((bus_rdata & it.mask) !== (it.exp & it.mask)) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h (mask %08h)",
                     it.tag, bus_rdata & it.mask, it.exp & it.mask, it.mask);
         end
      end
   end

   task automatic rd_exp(input logic [11:0] a, input logic [31:0] e,
                         input logic [31:0] m, input string tag);
      item_t it;
      @(posedge clk); #1;
      bus_addr = a;
      bus_we   = 1'b0;
      it.exp = e; it.mask = m; it.tag = tag;
      sb_q.push_back(it);
      rd_pend = 1'b1;
      @(negedge clk); #1;
      rd_pend = 1'b0;
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(posedge clk); #1;
      bus_we = 1'b0;
   endtask

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
      end
   endtask

   task automatic wait_idle(input int bitpos, input string tag);
      int cycles = 0;
      @(posedge clk); #1;
      bus_addr = A_CTRL;
      @(negedge clk);
      while (bus_rdata[bitpos] && cycles <= BUSY_LIMIT) begin
         @(negedge clk);
         cycles++;
      end
      chk(cycles <= BUSY_LIMIT, tag, cycles, BUSY_LIMIT);
   endtask

   initial begin
      #750000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset values
      rd_exp(A_CTRL, 32'h0000_4000, 32'hFFFF_FFFF, "R1 ctrl reset");
      rd_exp(A_WDOG, 32'h0, 32'hFFFF_FFFF, "R1 wdog reset");
      rd_exp(A_ERR,  32'h0, 32'hFFFF_FFFF, "R1 err reset");
      chk(osc_src_sel == 1'b0 && autosw_en == 1'b1, "R1 outputs", {osc_src_sel, autosw_en}, 2'b01);

      // R2 wrong key: bit 0 held, bit 14 still written
      wr(A_CTRL, 32'h1234_0001);
      rd_exp(A_CTRL, 32'h0000_0000, 32'hFFFF_FFFF, "R2 wrong key");
      // R2 correct key
      wr(A_CTRL, 32'h16AA_4001);
      rd_exp(A_CTRL, 32'h0000_4001, 32'hFFFF_FFFF, "R2 right key");
      chk(osc_src_sel == 1'b1, "R2 src output", osc_src_sel, 1);
      wr(A_CTRL, 32'h16AB_4000);
      rd_exp(A_CTRL, 32'h0000_4001, 32'hFFFF_FFFF, "R2 near-miss key");

      // R3 and R7 reserved and busy bits ignore writes
      wr(A_CTRL, 32'h16AA_7FFF);
      rd_exp(A_CTRL, 32'h0000_4001, 32'hFFFF_FFFF, "R3 R7 ctrl zero fields");

      // R4 pending read/write
      wr(A_CTRL, 32'h16AA_C001);
      rd_exp(A_CTRL, 32'h0000_C001, 32'hFFFF_FFFF, "R4 pend write");
      // R4 event and write of 0 in the same cycle: event wins
      @(posedge clk); #1;
      osc_autosw_evt = 1'b1;
      bus_addr = A_CTRL; bus_wdata = 32'h16AA_0000; bus_we = 1'b1;
      @(posedge clk); #1;
      osc_autosw_evt = 1'b0; bus_we = 1'b0;
      rd_exp(A_CTRL, 32'h0000_8000, 32'hFFFF_FFFF, "R4 event priority");
      wr(A_CTRL, 32'h16AA_4000);
      rd_exp(A_CTRL, 32'h0000_4000, 32'hFFFF_FFFF, "R4 pend clear");

      // R10 watchdog register
      wr(A_WDOG, 32'hFFFF_FFFF);
      rd_exp(A_WDOG, 32'h0000_0003, 32'hFFFF_FFFF, "R10 R3 wdog all");
      chk(wdog_en && wdog_rst_en, "R10 wdog outputs", {wdog_rst_en, wdog_en}, 2'b11);
      wr(A_WDOG, 32'h0000_0002);
      rd_exp(A_WDOG, 32'h0000_0002, 32'hFFFF_FFFF, "R10 wdog rst only");

      // R5 R6 time write
      wr(A_TIME, 32'hA5A5_0001);
      rd_exp(A_CTRL, 32'h0000_0100, 32'h0000_0300, "R5 time busy set");
      chk(time_data == 32'hA5A5_0001, "R5 time data", time_data, 32'hA5A5_0001);
      wait_idle(8, "R6 time busy clears");
      chk(tload_n == 1 && tload_dat == 32'hA5A5_0001, "R6 time load", tload_dat, 32'hA5A5_0001);

      // R5 R6 R7 alarm write; software write of bit 9 has no effect
      wr(A_ALARM, 32'h0102_0304);
      wr(A_CTRL, 32'h16AA_4000);
      rd_exp(A_CTRL, 32'h0000_0200, 32'h0000_0300, "R7 alarm busy not cleared by write");
      chk(alarm_data == 32'h0102_0304, "R5 alarm data", alarm_data, 32'h0102_0304);
      wait_idle(9, "R6 alarm busy clears");
      chk(aload_n == 1 && aload_dat == 32'h0102_0304, "R6 alarm load", aload_dat, 32'h0102_0304);

      // R8 collision on time channel
      wr(A_TIME, 32'h1111_1111);
      wr(A_TIME, 32'h2222_2222);
      rd_exp(A_ERR, 32'h0000_0001, 32'hFFFF_FFFF, "R8 time drop error");
      chk(time_data == 32'h1111_1111, "R8 time data kept", time_data, 32'h1111_1111);
      wait_idle(8, "R6 time busy clears after drop");
      repeat (40) @(posedge clk);
      chk(tload_n == 2 && tload_dat == 32'h1111_1111, "R8 single load", tload_n, 2);
      rd_exp(A_ERR, 32'h0000_0001, 32'hFFFF_FFFF, "R8 error sticky");

      // R9 write-one-to-clear
      wr(A_ERR, 32'h0000_0002);
      rd_exp(A_ERR, 32'h0000_0001, 32'hFFFF_FFFF, "R9 zero write keeps");
      wr(A_ERR, 32'h0000_0001);
      rd_exp(A_ERR, 32'h0000_0000, 32'hFFFF_FFFF, "R9 one clears");

      // R8 collision on alarm channel
      wr(A_ALARM, 32'h3333_3333);
      wr(A_ALARM, 32'h4444_4444);
      rd_exp(A_ERR, 32'h0000_0002, 32'hFFFF_FFFF, "R8 alarm drop error");
      chk(alarm_data == 32'h3333_3333, "R8 alarm data kept", alarm_data, 32'h3333_3333);
      wait_idle(9, "R6 alarm busy clears after drop");
      repeat (40) @(posedge clk);
      chk(aload_n == 2, "R8 alarm single load", aload_n, 2);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule